// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block sits on the PHY side of a two-wire management link and decodes the classic 32-bit-preamble management frames. MDC and MDIO arrive as asynchronous levels. They are resynchronised into the system clock, and every MDC transition is turned into a one-cycle edge event. A frame decoder walks through the fields in order: preamble, start pattern, opcode, PHY address, register address, turnaround and data. It counts MDC edges (two per bit) to find each field boundary.

A read frame (opcode binary 10) fetches one 16-bit word from an attached register port at the end of turnaround. The block then drives that word onto MDIO most significant bit first, with each bit changing after a falling MDC edge. Any other opcode is treated as a write. The 16 incoming bits are collected on rising MDC edges, and a single write strobe is issued once the last bit has arrived. Only one PHY address is answered. A read to any other address returns all ones and never touches the register port, and a write to another address is dropped. A start pattern whose second bit is not 1 raises a sticky error flag, but the frame is decoded anyway.

Top module: `mdio_frame_slave`

## Requirements
- R1: After reset, mdio_oe, mdio_out, reg_rd, reg_wr and start_err are all 0, and the edge counter starts from zero.
- R2: The decoder leaves the preamble only on a rising MDC edge that samples MDIO low, and only once at least 64 MDC edges have been counted since reset or since the previous frame ended. A low bit sampled on edge 63 is ignored.
- R3: If the bit after the start-pattern 0 is sampled low, start_err goes to 1 and stays at 1 until reset. The frame is still decoded and served normally.
- R4: Opcode, PHY address and register address are taken MSB first. Opcode 2'b10 is a read. At the rising edge that ends turnaround, reg_rd pulses for one cycle with reg_phy and reg_addr holding the decoded fields, and reg_rdata is sampled in that same cycle.
- R5: During a read, mdio_oe rises at the end of turnaround. Each following falling MDC edge presents the next data bit, MSB first, on mdio_out, and mdio_out holds steady between falling edges. mdio_oe drops at the rising edge of the 16th data bit.
- R6: A read to a PHY address other than OWN_PHY (default 1) drives 16'hFFFF and produces no reg_rd pulse.
- R7: Opcodes 2'b00, 2'b01 and 2'b11 are writes. The 16 data bits are shifted in MSB first on rising MDC edges. A single one-cycle reg_wr pulse follows the 16th bit, with reg_wdata, reg_phy and reg_addr holding the frame's values.
- R8: A write to a PHY address other than OWN_PHY produces no reg_wr pulse.
- R9: mdio_oe stays 0 for the whole of every write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc | input | 1 | Management clock level, asynchronous |
| mdio_in | input | 1 | Management data level seen on the wire |
| mdio_out | output | 1 | Data value driven during reads |
| mdio_oe | output | 1 | Drive enable for mdio_out |
| reg_phy | output | 5 | Decoded PHY address |
| reg_addr | output | 5 | Decoded register address |
| reg_rd | output | 1 | One-cycle read request, data sampled in the same cycle |
| reg_rdata | input | 16 | Register word returned combinationally for reg_addr |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Write data, valid with reg_wr |
| start_err | output | 1 | Sticky flag for a malformed start pattern |

## Verification
The assertions assume that MDIO is stable around each rising MDC edge and that MDC stays at each level for several system clocks, so every transition survives the synchronizer as exactly one edge event. They also assume that reg_rdata follows reg_addr within the same cycle. The stimulus changes mdio_in only while MDC is low and holds each MDC half-period for six clocks. It models the register port as a pure function of the address. Under these conditions the bench sweeps every register address in both directions, several absent PHY addresses, every write opcode, a preamble that ends one edge too early, and a malformed start pattern.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

   typedef enum logic [2:0] {
      ST_PRE   = 3'd0,
      ST_START = 3'd1,
      ST_OP    = 3'd2,
      ST_PHY   = 3'd3,
      ST_REG   = 3'd4,
      ST_TA    = 3'd5,
      ST_DATA  = 3'd6
   } frame_st_e;

   localparam logic [1:0] OP_READ = 2'b10;

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc_raw,
   input  logic mdio_raw,
   output logic mdio_s,
   output logic rise,
   output logic fall
);

   logic mdc_s;
   logic mdc_d;

   generate
      if (STAGES == 0) begin : g_bypass
         assign mdc_s  = mdc_raw;
         assign mdio_s = mdio_raw;
      end else begin : g_chain
         logic [STAGES-1:0] c_mdc;
         logic [STAGES-1:0] c_mdio;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               c_mdc  <= '0;
               c_mdio <= '0;
            end else begin
               c_mdc[0]  <= mdc_raw;
               c_mdio[0] <= mdio_raw;
               for (int i = 1; i < STAGES; i++) begin
                  c_mdc[i]  <= c_mdc[i-1];
                  c_mdio[i] <= c_mdio[i-1];
               end
            end
         end
         assign mdc_s  = c_mdc[STAGES-1];
         assign mdio_s = c_mdio[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) mdc_d <= 1'b0;
      else        mdc_d <= mdc_s;
   end

   assign rise = mdc_s & ~mdc_d;
   assign fall = ~mdc_s & mdc_d;

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
   import mdio_slv_pkg::*;
#(
   parameter int              PHY_W     = 5,
   parameter int              REG_W     = 5,
   parameter int              DATA_W    = 16,
   parameter int              PRE_EDGES = 64,
   parameter int              OWN_PHY   = 1,
   parameter logic [DATA_W-1:0] ABSENT  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              fall,
   input  logic              mdio_s,
   output logic [PHY_W-1:0]  reg_phy,
   output logic [REG_W-1:0]  reg_addr,
   output logic              reg_rd,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              reg_wr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              mdio_out,
   output logic              mdio_oe,
   output logic              start_err
);

   localparam int CNT_MAX0 = (PRE_EDGES > 2*DATA_W) ? PRE_EDGES : 2*DATA_W;
   localparam int CNT_MAX1 = (CNT_MAX0 > 2*PHY_W) ? CNT_MAX0 : 2*PHY_W;
   localparam int CNT_MAX  = (CNT_MAX1 > 2*REG_W) ? CNT_MAX1 : 2*REG_W;
   localparam int CNT_W    = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] E_PRE   = CNT_W'(PRE_EDGES);
   localparam logic [CNT_W-1:0] E_START = CNT_W'(2);
   localparam logic [CNT_W-1:0] E_OP    = CNT_W'(4);
   localparam logic [CNT_W-1:0] E_PHY   = CNT_W'(2*PHY_W);
   localparam logic [CNT_W-1:0] E_REG   = CNT_W'(2*REG_W);
   localparam logic [CNT_W-1:0] E_TA    = CNT_W'(4);
   localparam logic [CNT_W-1:0] E_DATA  = CNT_W'(2*DATA_W);
   localparam logic [PHY_W-1:0] MY_PHY  = PHY_W'(OWN_PHY);

   frame_st_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_inc;
   logic [1:0]        op_q;
   logic [PHY_W-1:0]  phy_q;
   logic [REG_W-1:0]  reg_q;
   logic [DATA_W-1:0] sh_q;
   logic              any_edge;
   logic              phy_hit;
   logic              ta_done;
   logic              data_done;

   assign any_edge  = rise | fall;
   assign cnt_inc   = (&cnt) ? cnt : cnt + 1'b1;
   assign phy_hit   = (phy_q == MY_PHY);
   assign ta_done   = (st == ST_TA) && rise && (cnt_inc == E_TA);
   assign data_done = (st == ST_DATA) && rise && (cnt_inc == E_DATA);

   assign reg_rd    = ta_done && (op_q == OP_READ) && phy_hit;
   assign reg_phy   = phy_q;
   assign reg_addr  = reg_q;
   assign reg_wdata = sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_PRE;
         cnt       <= '0;
         op_q      <= '0;
         phy_q     <= '0;
         reg_q     <= '0;
         sh_q      <= '0;
         mdio_out  <= 1'b0;
         mdio_oe   <= 1'b0;
         reg_wr    <= 1'b0;
         start_err <= 1'b0;
      end else begin
         reg_wr <= 1'b0;
         if (any_edge) begin
            cnt <= cnt_inc;
            unique case (st)
               ST_PRE: begin
                  if (rise && !mdio_s && cnt_inc >= E_PRE) begin
                     cnt <= '0;
                     st  <= ST_START;
                  end
               end
               ST_START: begin
                  if (rise) begin
                     if (!mdio_s) start_err <= 1'b1;
                     if (cnt_inc == E_START) begin
                        cnt <= '0;
                        st  <= ST_OP;
                     end
                  end
               end
               ST_OP: begin
                  if (rise) begin
                     op_q <= {op_q[0], mdio_s};
                     if (cnt_inc == E_OP) begin
                        cnt <= '0;
                        st  <= ST_PHY;
                     end
                  end
               end
               ST_PHY: begin
                  if (rise) begin
                     phy_q <= {phy_q[PHY_W-2:0], mdio_s};
                     if (cnt_inc == E_PHY) begin
                        cnt <= '0;
                        st  <= ST_REG;
                     end
                  end
               end
               ST_REG: begin
                  if (rise) begin
                     reg_q <= {reg_q[REG_W-2:0], mdio_s};
                     if (cnt_inc == E_REG) begin
                        cnt <= '0;
                        st  <= ST_TA;
                     end
                  end
               end
               ST_TA: begin
                  if (ta_done) begin
                     cnt <= '0;
                     st  <= ST_DATA;
                     if (op_q == OP_READ) begin
                        mdio_oe  <= 1'b1;
                        mdio_out <= 1'b0;
                        sh_q     <= phy_hit ? reg_rdata : ABSENT;
                     end
                  end
               end
               ST_DATA: begin
                  if (fall && mdio_oe) begin
                     mdio_out <= sh_q[DATA_W-1];
                     sh_q     <= {sh_q[DATA_W-2:0], 1'b0};
                  end
                  if (rise && !mdio_oe) sh_q <= {sh_q[DATA_W-2:0], mdio_s};
                  if (data_done) begin
                     cnt     <= '0;
                     st      <= ST_PRE;
                     mdio_oe <= 1'b0;
                     if (!mdio_oe && phy_hit) reg_wr <= 1'b1;
                  end
               end
               default: st <= ST_PRE;
            endcase
         end
      end
   end

   AST_PRE_EXIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_START && $past(st) == ST_PRE) |-> !$past(mdio_s)); // R2
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      start_err |=> start_err); // R3
   AST_RD_THEN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> mdio_oe); // R4
   AST_OE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> st == ST_DATA); // R5
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && $past(st) == ST_DATA && mdio_oe && !fall) |=> $stable(mdio_out)); // R5
   AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr); // R7
   AST_WR_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> reg_phy == MY_PHY); // R8
   AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> !mdio_oe && !$past(mdio_oe)); // R9

endmodule

// File: rtl/mdio_frame_slave.sv
module mdio_frame_slave #(
   parameter int PHY_W       = 5,
   parameter int REG_W       = 5,
   parameter int DATA_W      = 16,
   parameter int PRE_EDGES   = 64,
   parameter int SYNC_STAGES = 2,
   parameter int OWN_PHY     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mdc,
   input  logic              mdio_in,
   output logic              mdio_out,
   output logic              mdio_oe,
   output logic [PHY_W-1:0]  reg_phy,
   output logic [REG_W-1:0]  reg_addr,
   output logic              reg_rd,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              reg_wr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              start_err
);

   generate
      if (PHY_W < 2 || REG_W < 2 || DATA_W < 2) begin : g_bad_width
         $error("mdio_frame_slave: field widths must be at least 2");
      end
      if (OWN_PHY < 0 || OWN_PHY >= (1 << PHY_W)) begin : g_bad_phy
         $error("mdio_frame_slave: OWN_PHY does not fit PHY_W");
      end
      if (SYNC_STAGES < 0 || PRE_EDGES < 1) begin : g_bad_cfg
         $error("mdio_frame_slave: bad synchronizer or preamble setting");
      end
   endgenerate

   logic mdio_s;
   logic rise;
   logic fall;

   mdio_edge_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .mdc_raw  (mdc),
      .mdio_raw (mdio_in),
      .mdio_s   (mdio_s),
      .rise     (rise),
      .fall     (fall)
   );

   mdio_frame_fsm #(
      .PHY_W     (PHY_W),
      .REG_W     (REG_W),
      .DATA_W    (DATA_W),
      .PRE_EDGES (PRE_EDGES),
      .OWN_PHY   (OWN_PHY),
      .ABSENT    ('1)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (rise),
      .fall      (fall),
      .mdio_s    (mdio_s),
      .reg_phy   (reg_phy),
      .reg_addr  (reg_addr),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .mdio_out  (mdio_out),
      .mdio_oe   (mdio_oe),
      .start_err (start_err)
   );

endmodule

// File: tb/mdio_frame_slave_test.sv
module mdio_frame_slave_test;

   localparam int HALF = 6;
   localparam int OWN  = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mdc = 1'b0;
   logic        mdio_in = 1'b1;
   logic        mdio_out;
   logic        mdio_oe;
   logic [4:0]  reg_phy;
   logic [4:0]  reg_addr;
   logic        reg_rd;
   logic [15:0] reg_rdata;
   logic        reg_wr;
   logic [15:0] reg_wdata;
   logic        start_err;

   int n_cmp = 0;
   int n_bad = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   logic [4:0]  rd_phy, rd_reg, wr_phy, wr_reg;
   logic [15:0] wr_dat;
   logic        samp_out, samp_oe;
   logic [15:0] got_rd;
   logic        oe_seen;
   logic        oe_all;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   function automatic logic [15:0] reg_model(input logic [4:0] a);
      return {a, ~a, 6'b101001};
   endfunction

   assign reg_rdata = reg_model(reg_addr);

   mdio_frame_slave uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mdc       (mdc),
      .mdio_in   (mdio_in),
      .mdio_out  (mdio_out),
      .mdio_oe   (mdio_oe),
      .reg_phy   (reg_phy),
      .reg_addr  (reg_addr),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .start_err (start_err)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_rd) begin
            rd_cnt = rd_cnt + 1;
            rd_phy = reg_phy;
            rd_reg = reg_addr;
         end
         if (reg_wr) begin
            wr_cnt = wr_cnt + 1;
            wr_phy = reg_phy;
            wr_reg = reg_addr;
            wr_dat = reg_wdata;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      mdio_in = b;
      repeat (HALF) @(negedge clk);
      samp_out = mdio_out;
      samp_oe  = mdio_oe;
      mdc = 1'b1;
      repeat (HALF) @(negedge clk);
      mdc = 1'b0;
   endtask

   task automatic frame(input logic st2, input logic [1:0] op, input logic [4:0] phy,
                        input logic [4:0] ra, input logic [15:0] wd);
      oe_seen = 1'b0;
      oe_all  = 1'b1;
      got_rd  = '0;
      for (int i = 0; i < 32; i++) send_bit(1'b1);
      send_bit(1'b0);
      send_bit(st2);
      for (int i = 1; i >= 0; i--) begin send_bit(op[i]); oe_seen |= samp_oe; end
      for (int i = 4; i >= 0; i--) begin send_bit(phy[i]); oe_seen |= samp_oe; end
      for (int i = 4; i >= 0; i--) begin send_bit(ra[i]); oe_seen |= samp_oe; end
      send_bit(1'b1); oe_seen |= samp_oe;
      send_bit(1'b0); oe_seen |= samp_oe;
      for (int i = 15; i >= 0; i--) begin
         send_bit((op == 2'b10) ? 1'b0 : wd[i]);
         got_rd[i] = samp_out;
         oe_seen |= samp_oe;
         oe_all  &= samp_oe;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      mdc = 1'b0;
      mdio_in = 1'b1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int r0, w0;
      do_reset();
      // R1 reset state
      check("R1 oe", mdio_oe, 0);
      check("R1 out", mdio_out, 0);
      check("R1 rd", reg_rd, 0);
      check("R1 wr", reg_wr, 0);
      check("R1 err", start_err, 0);

      // R2: 31 ones then a low bit lands on edge 63 and must be ignored
      for (int i = 0; i < 31; i++) send_bit(1'b1);
      send_bit(1'b0);
      r0 = rd_cnt;
      frame(1'b1, 2'b10, 5'(OWN), 5'd9, 16'h0);
      check("R2 early low ignored, next read served", rd_cnt - r0, 1);
      check("R2 read data", got_rd, reg_model(5'd9));

      // R7 / R9 write sweep over all registers
      for (int a = 0; a < 32; a++) begin
         logic [15:0] wd;
         wd = 16'(a * 16'h0841) ^ 16'h5A3C;
         w0 = wr_cnt;
         frame(1'b1, 2'b01, 5'(OWN), 5'(a), wd);
         check("R7 one strobe", wr_cnt - w0, 1);
         check("R7 addr", {wr_phy, wr_reg}, {5'(OWN), 5'(a)});
         check("R7 data", wr_dat, wd);
         check("R9 no drive", oe_seen, 0);
      end

      // R4 / R5 read sweep over all registers
      for (int a = 0; a < 32; a++) begin
         r0 = rd_cnt;
         frame(1'b1, 2'b10, 5'(OWN), 5'(a), 16'h0);
         check("R4 one read", rd_cnt - r0, 1);
         check("R4 addr", {rd_phy, rd_reg}, {5'(OWN), 5'(a)});
         check("R5 data msb first", got_rd, reg_model(5'(a)));
         check("R5 oe through data", oe_all, 1);
         check("R5 oe released", mdio_oe, 0);
      end

      // R6 reads to absent PHY addresses
      for (int k = 0; k < 4; k++) begin
         logic [4:0] p;
         p = (k == 0) ? 5'd0 : (k == 1) ? 5'd2 : (k == 2) ? 5'd17 : 5'd31;
         r0 = rd_cnt;
         frame(1'b1, 2'b10, p, 5'd4, 16'h0);
         check("R6 all ones", got_rd, 16'hFFFF);
         check("R6 no port read", rd_cnt - r0, 0);
      end

      // R8 writes to absent PHY addresses
      for (int k = 0; k < 3; k++) begin
         logic [4:0] p;
         p = (k == 0) ? 5'd0 : (k == 1) ? 5'd5 : 5'd31;
         w0 = wr_cnt;
         frame(1'b1, 2'b01, p, 5'd7, 16'hBEEF);
         check("R8 no strobe", wr_cnt - w0, 0);
      end

      // R7 other write opcodes
      w0 = wr_cnt;
      frame(1'b1, 2'b11, 5'(OWN), 5'd12, 16'h1357);
      check("R7 op 11 writes", wr_cnt - w0, 1);
      check("R7 op 11 data", wr_dat, 16'h1357);
      w0 = wr_cnt;
      frame(1'b1, 2'b00, 5'(OWN), 5'd30, 16'h8001);
      check("R7 op 00 writes", wr_cnt - w0, 1);
      check("R7 op 00 data", wr_dat, 16'h8001);
      check("R9 op 00 no drive", oe_seen, 0);

      // R3 malformed start pattern
      check("R3 clear before", start_err, 0);
      r0 = rd_cnt;
      frame(1'b0, 2'b10, 5'(OWN), 5'd21, 16'h0);
      check("R3 flag set", start_err, 1);
      check("R3 frame still served", got_rd, reg_model(5'd21));
      check("R3 read issued", rd_cnt - r0, 1);
      frame(1'b1, 2'b01, 5'(OWN), 5'd3, 16'h0F0F);
      check("R3 flag sticky", start_err, 1);

      do_reset();
      check("R1 err cleared by reset", start_err, 0);
      check("R1 oe after reset", mdio_oe, 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule